// File: doc/BRIEF.md
# Quadrature Event Counter

This block tracks position or event totals from an incremental encoder, a step/direction source or a pair of count pulse lines. Three raw pins are each passed through a two-stage synchronizer and a filter whose hold length is programmable. The filtered levels drive a 32-bit signed up/down counter. A two-bit mode input picks how the first two pins are decoded. The choices are Gray-coded quadrature, a plain two-bit binary phase code, a count pin with a direction level, or independent up and down pulse lines.

The third pin serves either as an index marker or as a push-button. As a marker, its filtered rising edge clears the counter. As a button, the counter ignores it and its filtered level is simply presented on an output. Two signed limits guard the count. A step that carries the count past a limit either raises a sticky interrupt flag, or, when automatic zeroing is selected, loads zero in place of the stepped value. A single-cycle strobe marks every accepted step, so that an interval timer outside this block can time successive events.

Top module: `qcnt_top`

## Requirements
- R1: After reset, count is 0, count_evt is 0, and irq_hi, irq_lo and err_flag are all 0.
- R2: In mode 0 (quadrature) the {A,B} phase order 00, 01, 11, 10, 00 steps the count by +1 per transition, and the reverse order steps it by -1.
- R3: In mode 0, a change of both bits at once (for example 00 to 11) sets the sticky err_flag and leaves the count unchanged. Writing 1 to flag_clr[2] clears err_flag.
- R4: In mode 1 (direction), each filtered rising edge of A adds 1 when B is 0 and subtracts 1 when B is 1. A falling edge of A does not change the count.
- R5: In mode 2 (up/down lines), a filtered rising edge of A adds 1 and a filtered rising edge of B subtracts 1. Rising edges on both in the same cycle leave the count unchanged.
- R6: In mode 3 (binary), the {A,B} order 00, 01, 10, 11, 00 counts up and the reverse order counts down. A jump of two codes sets err_flag and does not change the count.
- R7: With dbnc_len = N of 1 or more, a pin level must be held N cycles before it is accepted, so a pulse shorter than N cycles has no effect. N = 0 bypasses the filter, and a one-cycle pulse is then counted.
- R8: With marker_en = 1, a filtered rising edge on Z clears the count without a count_evt pulse. With marker_en = 0, Z does not affect the count, and button shows the filtered Z level.
- R9: With bound_auto = 0, an up step whose result is greater than bound_hi (signed) sets irq_hi, and the count takes the stepped value. A result equal to bound_hi does not set the flag.
- R10: With bound_auto = 0, a down step whose result is less than bound_lo (signed) sets irq_lo, and the count takes the stepped value.
- R11: With bound_auto = 1, a step that would pass either limit loads 0 into the count, and neither interrupt flag is raised.
- R12: irq_hi and irq_lo stay set until a 1 is written to flag_clr[0] or flag_clr[1] respectively. A new crossing in the same cycle as the clear takes precedence.
- R13: count_evt pulses for exactly one cycle on each accepted +1 or -1 step. It does not pulse for illegal transitions, nor for marker clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_a | input | 1 | Raw count pin A |
| enc_b | input | 1 | Raw count pin B |
| enc_z | input | 1 | Raw marker / button pin |
| mode | input | 2 | 0 quadrature, 1 direction, 2 up/down lines, 3 binary |
| dbnc_len | input | 8 | Filter hold length in cycles, 0 = bypass |
| marker_en | input | 1 | Z rising edge clears the count |
| bound_auto | input | 1 | Passing a limit zeroes the count instead of flagging |
| bound_hi | input | 32 | Signed upper limit |
| bound_lo | input | 32 | Signed lower limit |
| flag_clr | input | 3 | Write-one clear: [0] irq_hi, [1] irq_lo, [2] err_flag |
| count | output | 32 | Signed counter value |
| count_evt | output | 1 | One-cycle strobe per accepted step |
| irq_hi | output | 1 | Sticky upper-limit flag |
| irq_lo | output | 1 | Sticky lower-limit flag |
| err_flag | output | 1 | Sticky illegal-transition flag |
| button | output | 1 | Filtered Z level |

## Verification
A pin change applied before a rising edge passes through two synchronizer flops and the filter register. It therefore reaches the filtered level at the third edge when N is 0 and at edge N+2 otherwise. The decoded step lands in count, count_evt and the flags one edge later. The bench drives and samples only at falling edges, and waits 2N+8 cycles after every pin change before it reads results, so each read falls well after the due edge and before the next stimulus. Strobes are tallied by a counter in the bench and compared against the number of legal steps in each phase.

// File: rtl/qcnt_pkg.sv
package qcnt_pkg;

  typedef enum logic [1:0] {
    MODE_QUAD = 2'd0,
    MODE_DIR  = 2'd1,
    MODE_UPDN = 2'd2,
    MODE_BIN  = 2'd3
  } qmode_e;

  typedef struct packed {
    logic up;
    logic dn;
    logic err;
  } qstep_t;

  // position of a Gray-coded {A,B} pair along the forward cycle
  function automatic logic [1:0] gray_pos(input logic [1:0] ab);
    case (ab)
      2'b00:   gray_pos = 2'd0;
      2'b01:   gray_pos = 2'd1;
      2'b11:   gray_pos = 2'd2;
      default: gray_pos = 2'd3;
    endcase
  endfunction

  // classify a move between two cycle positions by its modulo-4 distance
  function automatic qstep_t phase_move(input logic [1:0] p_old, input logic [1:0] p_new);
    logic [1:0] d;
    d = p_new - p_old;
    phase_move.up  = (d == 2'd1);
    phase_move.dn  = (d == 2'd3);
    phase_move.err = (d == 2'd2);
  endfunction

  function automatic qstep_t decode_step(input qmode_e m, input logic [1:0] prv,
                                         input logic [1:0] cur);
    logic rise_a, rise_b;
    rise_a = !prv[1] && cur[1];
    rise_b = !prv[0] && cur[0];
    decode_step = '0;
    case (m)
      MODE_QUAD: decode_step = phase_move(gray_pos(prv), gray_pos(cur));
      MODE_BIN:  decode_step = phase_move(prv, cur);
      MODE_DIR: begin
        decode_step.up = rise_a && !cur[0];
        decode_step.dn = rise_a && cur[0];
      end
      default: begin
        decode_step.up = rise_a && !rise_b;
        decode_step.dn = rise_b && !rise_a;
      end
    endcase
  endfunction

endpackage

// File: rtl/qcnt_filter.sv
module qcnt_filter #(
  parameter int DB_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pin,
  input  logic [DB_W-1:0] len,
  output logic            level
);
  logic            s1, s2;
  logic [DB_W-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= 1'b0;
      s2    <= 1'b0;
      level <= 1'b0;
      run   <= '0;
    end else begin
      s1 <= pin;
      s2 <= s1;
      if (len == '0) begin
        level <= s2;
        run   <= '0;
      end else if (s2 == level) begin
        run <= '0;
      end else if (run == len - DB_W'(1)) begin
        level <= s2;
        run   <= '0;
      end else begin
        run <= run + DB_W'(1);
      end
    end
  end

  // R7: with a hold length of two or more, a new level was seen on two consecutive cycles
  a_r7_stable_before_take: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(level) && $past(len) >= DB_W'(2)) |-> ($past(s2) == $past(s2, 2)));

endmodule

// File: rtl/qcnt_decode.sv
module qcnt_decode
  import qcnt_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  qmode_e       mode,
  input  logic [1:0]   ab,
  output qstep_t       step
);
  logic [1:0] prv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prv <= 2'b00;
    else        prv <= ab;
  end

  assign step = decode_step(mode, prv, ab);

  // R3 R6: an illegal jump never also produces a count step
  a_r3_err_excludes_step: assert property (@(posedge clk) disable iff (!rst_n)
    step.err |-> (!step.up && !step.dn));

  // R5: never both directions at once
  a_r5_single_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(step.up && step.dn));

endmodule

// File: rtl/qcnt_core.sv
module qcnt_core
  import qcnt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  qstep_t              step,
  input  logic                zm_clr,
  input  logic                auto_zero,
  input  logic signed [W-1:0] upper,
  input  logic signed [W-1:0] lower,
  input  logic [2:0]          flag_clr,
  output logic signed [W-1:0] cnt,
  output logic                evt,
  output logic                irq_u,
  output logic                irq_l,
  output logic                err
);
  logic signed [W-1:0] inc, dec, nxt;
  logic                hit_u, hit_l, set_u, set_l, take;

  assign inc   = cnt + W'(1);
  assign dec   = cnt - W'(1);
  assign hit_u = step.up && (inc > upper);
  assign hit_l = step.dn && (dec < lower);
  assign set_u = !zm_clr && hit_u && !auto_zero;
  assign set_l = !zm_clr && hit_l && !auto_zero;
  assign take  = !zm_clr && (step.up || step.dn);

  always_comb begin
    nxt = cnt;
    if (zm_clr)        nxt = '0;
    else if (step.up)  nxt = (hit_u && auto_zero) ? '0 : inc;
    else if (step.dn)  nxt = (hit_l && auto_zero) ? '0 : dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      evt   <= 1'b0;
      irq_u <= 1'b0;
      irq_l <= 1'b0;
      err   <= 1'b0;
    end else begin
      cnt   <= nxt;
      evt   <= take;
      irq_u <= set_u    ? 1'b1 : (flag_clr[0] ? 1'b0 : irq_u);
      irq_l <= set_l    ? 1'b1 : (flag_clr[1] ? 1'b0 : irq_l);
      err   <= step.err ? 1'b1 : (flag_clr[2] ? 1'b0 : err);
    end
  end

  // R8: a marker clear empties the counter on the next edge
  a_r8_marker_clears: assert property (@(posedge clk) disable iff (!rst_n)
    zm_clr |=> (cnt == '0));

  // R3: an illegal transition leaves the count alone and raises the flag
  a_r3_hold_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    (step.err && !zm_clr) |=> ($stable(cnt) && err));

  // R13: no step and no clear means no movement and no strobe
  a_r13_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!step.up && !step.dn && !zm_clr) |=> ($stable(cnt) && !evt));

  // R13: every accepted step strobes
  a_r13_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ((step.up || step.dn) && !zm_clr) |=> evt);

  // R9: crossing the upper limit in flag mode raises irq_u
  a_r9_upper_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_u && !auto_zero && !zm_clr) |=> irq_u);

  // R11: crossing a limit in auto mode zeroes the count
  a_r11_auto_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_u || hit_l) && auto_zero && !zm_clr) |=> (cnt == '0));

  // R12: flags hold until cleared
  a_r12_sticky_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_u && !flag_clr[0]) |=> irq_u);
  a_r12_sticky_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_l && !flag_clr[1]) |=> irq_l);

endmodule

// File: rtl/qcnt_top.sv
module qcnt_top
  import qcnt_pkg::*;
#(
  parameter int W    = 32,
  parameter int DB_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enc_a,
  input  logic            enc_b,
  input  logic            enc_z,
  input  logic [1:0]      mode,
  input  logic [DB_W-1:0] dbnc_len,
  input  logic            marker_en,
  input  logic            bound_auto,
  input  logic [W-1:0]    bound_hi,
  input  logic [W-1:0]    bound_lo,
  input  logic [2:0]      flag_clr,
  output logic [W-1:0]    count,
  output logic            count_evt,
  output logic            irq_hi,
  output logic            irq_lo,
  output logic            err_flag,
  output logic            button
);
  localparam int NPIN = 3;

  logic [NPIN-1:0]     raw, lvl;
  logic                z_prv, zm_clr;
  qstep_t              step;
  logic signed [W-1:0] cnt_s;

  assign raw = {enc_a, enc_b, enc_z};

  for (genvar g = 0; g < NPIN; g++) begin : g_filt
    qcnt_filter #(.DB_W(DB_W)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (raw[g]),
      .len   (dbnc_len),
      .level (lvl[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) z_prv <= 1'b0;
    else        z_prv <= lvl[0];
  end

  assign zm_clr = marker_en && lvl[0] && !z_prv;
  assign button = lvl[0];

  qcnt_decode u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (qmode_e'(mode)),
    .ab    (lvl[2:1]),
    .step  (step)
  );

  qcnt_core #(.W(W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .zm_clr    (zm_clr),
    .auto_zero (bound_auto),
    .upper     (bound_hi),
    .lower     (bound_lo),
    .flag_clr  (flag_clr),
    .cnt       (cnt_s),
    .evt       (count_evt),
    .irq_u     (irq_hi),
    .irq_l     (irq_lo),
    .err       (err_flag)
  );

  assign count = cnt_s;

  // R8: with the marker disabled the Z pin never clears the count
  a_r8_marker_off: assert property (@(posedge clk) disable iff (!rst_n)
    !marker_en |-> !zm_clr);

endmodule

// File: tb/sim_qcnt_top.sv
module sim_qcnt_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_a = 1'b0, enc_b = 1'b0, enc_z = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [7:0]  dbnc_len = 8'd2;
  logic        marker_en = 1'b0, bound_auto = 1'b0;
  logic [31:0] bound_hi = 32'd1000, bound_lo = -32'sd1000;
  logic [2:0]  flag_clr = 3'b000;
  logic [31:0] count;
  logic        count_evt, irq_hi, irq_lo, err_flag, button;

  int tests = 0, fails = 0, evt_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  qcnt_top u0 (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_z(enc_z),
    .mode(mode), .dbnc_len(dbnc_len), .marker_en(marker_en), .bound_auto(bound_auto),
    .bound_hi(bound_hi), .bound_lo(bound_lo), .flag_clr(flag_clr),
    .count(count), .count_evt(count_evt), .irq_hi(irq_hi), .irq_lo(irq_lo),
    .err_flag(err_flag), .button(button)
  );

  always @(posedge clk) begin
    if (!rst_n) evt_cnt <= 0;
    else if (count_evt) evt_cnt <= evt_cnt + 1;
  end

  // entry: {A,B}, expected count, expected error flag
  localparam int NQ = 14;
  localparam logic [34:0] QTAB [NQ] = '{
    {2'b01, 32'd1,          1'b0},
    {2'b11, 32'd2,          1'b0},
    {2'b10, 32'd3,          1'b0},
    {2'b00, 32'd4,          1'b0},
    {2'b10, 32'd3,          1'b0},
    {2'b11, 32'd2,          1'b0},
    {2'b01, 32'd1,          1'b0},
    {2'b00, 32'd0,          1'b0},
    {2'b10, 32'hFFFF_FFFF,  1'b0},
    {2'b01, 32'hFFFF_FFFF,  1'b1},
    {2'b11, 32'd0,          1'b0},
    {2'b00, 32'd0,          1'b1},
    {2'b01, 32'd1,          1'b0},
    {2'b00, 32'd0,          1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (2 * int'(dbnc_len) + 8) @(negedge clk);
  endtask

  task automatic clear_flags(input logic [2:0] m);
    flag_clr = m;
    @(negedge clk);
    flag_clr = 3'b000;
    @(negedge clk);
  endtask

  task automatic pulse_a();
    enc_a = 1'b1; settle(); enc_a = 1'b0; settle();
  endtask

  task automatic pulse_b();
    enc_b = 1'b1; settle(); enc_b = 1'b0; settle();
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    int e0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 count", count, 32'd0);
    chk("R1 flags", {29'd0, irq_hi, irq_lo, err_flag}, 32'd0);
    chk("R1 evt", {31'd0, count_evt}, 32'd0);
    rst_n = 1'b1;
    settle();
    chk("R1 count after release", count, 32'd0);

    // R2 R3 quadrature table, R13 strobe tally
    e0 = evt_cnt;
    for (int i = 0; i < NQ; i++) begin
      {enc_a, enc_b} = QTAB[i][34:33];
      settle();
      chk("R2 quad count", count, QTAB[i][32:1]);
      chk("R3 quad err", {31'd0, err_flag}, {31'd0, QTAB[i][0]});
      if (QTAB[i][0]) begin
        clear_flags(3'b100);
        chk("R3 err cleared", {31'd0, err_flag}, 32'd0);
      end
    end
    chk("R13 strobes in quad table", evt_cnt - e0, 32'd12);

    // R6 binary phase code, count 0, AB 00
    mode = 2'd3;
    {enc_a, enc_b} = 2'b01; settle(); chk("R6 bin 01", count, 32'd1);
    {enc_a, enc_b} = 2'b10; settle(); chk("R6 bin 10", count, 32'd2);
    {enc_a, enc_b} = 2'b11; settle(); chk("R6 bin 11", count, 32'd3);
    {enc_a, enc_b} = 2'b00; settle(); chk("R6 bin wrap up", count, 32'd4);
    {enc_a, enc_b} = 2'b11; settle(); chk("R6 bin down", count, 32'd3);
    {enc_a, enc_b} = 2'b01; settle(); chk("R6 bin jump count", count, 32'd3);
    chk("R6 bin jump err", {31'd0, err_flag}, 32'd1);
    clear_flags(3'b100);
    {enc_a, enc_b} = 2'b00; settle(); chk("R6 bin down to 2", count, 32'd2);

    // R4 direction mode
    mode = 2'd1;
    enc_b = 1'b1; settle();
    chk("R4 direction level alone", count, 32'd2);
    enc_a = 1'b1; settle(); chk("R4 rise with B=1", count, 32'd1);
    enc_a = 1'b0; settle(); chk("R4 fall ignored", count, 32'd1);
    enc_b = 1'b0; settle();
    pulse_a(); chk("R4 rise with B=0", count, 32'd2);

    // R5 up/down lines
    mode = 2'd2;
    pulse_a(); chk("R5 up line", count, 32'd3);
    pulse_b(); chk("R5 down line", count, 32'd2);
    e0 = evt_cnt;
    {enc_a, enc_b} = 2'b11; settle();
    chk("R5 both rising", count, 32'd2);
    chk("R13 no strobe when cancelled", evt_cnt - e0, 32'd0);
    {enc_a, enc_b} = 2'b00; settle();

    // R7 filter
    dbnc_len = 8'd4;
    settle();
    enc_a = 1'b1; repeat (2) @(negedge clk); enc_a = 1'b0; settle();
    chk("R7 short glitch ignored", count, 32'd2);
    pulse_a(); chk("R7 held pulse counted", count, 32'd3);
    dbnc_len = 8'd0;
    settle();
    enc_a = 1'b1; @(negedge clk); enc_a = 1'b0; settle();
    chk("R7 bypass one-cycle pulse", count, 32'd4);
    dbnc_len = 8'd2;
    settle();

    // R8 marker / button
    enc_z = 1'b1; settle();
    chk("R8 button level", {31'd0, button}, 32'd1);
    chk("R8 marker off no clear", count, 32'd4);
    enc_z = 1'b0; settle();
    chk("R8 button low", {31'd0, button}, 32'd0);
    marker_en = 1'b1;
    e0 = evt_cnt;
    enc_z = 1'b1; settle();
    chk("R8 marker clears", count, 32'd0);
    chk("R13 no strobe on clear", evt_cnt - e0, 32'd0);
    enc_z = 1'b0; settle();
    marker_en = 1'b0;

    // R9 R10 R12 limits in flag mode
    bound_hi = 32'd3; bound_lo = -32'sd2;
    settle();
    repeat (3) pulse_a();
    chk("R9 at limit", count, 32'd3);
    chk("R9 no flag at limit", {31'd0, irq_hi}, 32'd0);
    pulse_a();
    chk("R9 passed count", count, 32'd4);
    chk("R9 flag set", {31'd0, irq_hi}, 32'd1);
    repeat (5) @(negedge clk);
    chk("R12 flag holds", {31'd0, irq_hi}, 32'd1);
    clear_flags(3'b001);
    chk("R12 flag cleared", {31'd0, irq_hi}, 32'd0);
    repeat (6) pulse_b();
    chk("R10 at limit", count, 32'hFFFF_FFFE);
    chk("R10 no flag at limit", {31'd0, irq_lo}, 32'd0);
    pulse_b();
    chk("R10 passed count", count, 32'hFFFF_FFFD);
    chk("R10 flag set", {31'd0, irq_lo}, 32'd1);
    clear_flags(3'b010);
    chk("R12 low flag cleared", {31'd0, irq_lo}, 32'd0);

    // R11 automatic zeroing
    bound_auto = 1'b1;
    pulse_b();
    chk("R11 lower auto zero", count, 32'd0);
    chk("R11 no low flag", {31'd0, irq_lo}, 32'd0);
    repeat (4) pulse_a();
    chk("R11 upper auto zero", count, 32'd0);
    chk("R11 no high flag", {31'd0, irq_hi}, 32'd0);

    done = 1;
    summary();
  end
endmodule